// File: doc/BRIEF.md
# Inbound Address Window Decoder

This block sits on the target side of a bus bridge and decides whether an incoming 32-bit bus address falls inside one of three programmable inbound windows. For a matching address it reports which window matched and the address to present to host memory. Every window maps onto host memory starting at address zero, so the host address is simply the distance of the incoming address from the window's aligned base.

Each window is set up by one 32-bit configuration word. The upper twelve bits give the window base at 1 MB granularity. A 4-bit code in bits 19..16 gives the window size as a power of two, from 1 MB to 2 GB. Codes that name a size beyond 2 GB leave the window switched off. Writes land on the next rising clock edge. The lookup from address to hit, index and host address is purely combinational, so the decode sits in whatever pipeline stage the surrounding bridge puts it in. When windows overlap, the lowest-numbered one wins.

Top module: `iwin_decoder`

## Requirements
- R1: After reset every window is disabled and `win_hit` stays low for any address until a window has been written with a legal size code.
- R2: A write with `cfg_wr_en` high and `cfg_wr_sel` equal to window k stores `cfg_wr_data[31:20]` as that window's base and `cfg_wr_data[19:16]` as its size code. The new setting affects the outputs only after the next rising clock edge.
- R3: Size code n (0 to 11) gives a window of 2^n MB. An address hits window k when its bits above bit 19+n equal the stored base bits above that position. The stored base is therefore aligned down to the window size.
- R4: Bits 15..0 of a configuration write are ignored.
- R5: A write carrying a size code of 12 to 15 leaves that window disabled, and the window never reports a hit until a later write gives it a legal code.
- R6: On a hit, `host_addr` equals `pci_addr` minus the window's size-aligned base. This is the address bits below bit 20+n, with the upper bits zero.
- R7: When an address hits several windows, `win_idx` names the lowest-numbered one, and `host_addr` is translated through that window.
- R8: When no window hits, `win_idx` and `host_addr` are both zero.
- R9: A write whose `cfg_wr_sel` does not name an existing window (value 3 with three windows) changes no window.
- R10: A new write to a window replaces its earlier base, size and enable state completely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; configuration writes land on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | 2 | Window selected by the write |
| cfg_wr_data | input | 32 | Window word: base in bits 31..20, size code in bits 19..16 |
| pci_addr | input | 32 | Incoming bus address to decode |
| win_hit | output | 1 | High when some enabled window contains `pci_addr` |
| win_idx | output | 2 | Index of the winning window, zero on a miss |
| host_addr | output | 32 | Translated host address, zero on a miss |

## Verification
The bench builds the block with its default parameters: three windows, a 32-bit address, a 12-bit base and a largest legal code of 11. With these values the 2 GB window decodes only on the top address bit, and a base that is not aligned to its size gets truncated. Because three windows leave the two-bit select with one unused value, the out-of-range write of R9 can be reached. The window layout nests a 16 MB window inside a 64 MB one, so the priority rule decides the shared addresses, and addresses one below and one above each edge show where the windows end.

// File: rtl/iwin_pkg.sv
package iwin_pkg;

    // Address and field geometry of one window word.
    localparam int ADDR_W = 32;
    localparam int BASE_W = 12;
    localparam int CODE_W = 4;
    localparam int GRAN_W = ADDR_W - BASE_W;   // 1 MB granule -> 20 bits
    localparam int CODE_LSB = GRAN_W - CODE_W;  // code sits just below base
    localparam int SHAMT_W = $clog2(ADDR_W + (1 << CODE_W));

    typedef struct packed {
        logic              en;
        logic [BASE_W-1:0] base;
        logic [CODE_W-1:0] code;
    } win_cfg_t;

endpackage

// File: rtl/iwin_regs.sv
module iwin_regs
    import iwin_pkg::*;
#(
    parameter int NUM_WIN  = 3,
    parameter int MAX_CODE = 11,
    localparam int IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_sel,
    input  logic [ADDR_W-1:0]      wr_data,
    output win_cfg_t [NUM_WIN-1:0] cfg
);

    typedef struct packed {
        win_cfg_t [NUM_WIN-1:0] win;
    } regs_state_t;

    regs_state_t state_d, state_q;

    logic [BASE_W-1:0] wr_base;
    logic [CODE_W-1:0] wr_code;
    logic              wr_legal;
    logic              sel_in_range;

    always_comb begin
        wr_base      = wr_data[ADDR_W-1 -: BASE_W];
        wr_code      = wr_data[CODE_LSB +: CODE_W];
        wr_legal     = (32'(wr_code) <= MAX_CODE);
        sel_in_range = (32'(wr_sel) < NUM_WIN);

        state_d = state_q;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (wr_en && sel_in_range && (32'(wr_sel) == i)) begin
                state_d.win[i].base = wr_base;
                state_d.win[i].code = wr_code;
                state_d.win[i].en   = wr_legal;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cfg = state_q.win;

    // Assertions on the register bank.
    generate
        for (genvar k = 0; k < NUM_WIN; k++) begin : g_reg_chk
            p_write_arms_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && (32'(wr_sel) == k) && (32'(wr_data[CODE_LSB +: CODE_W]) <= MAX_CODE))
                |=> (cfg[k].en && (cfg[k].base == $past(wr_data[ADDR_W-1 -: BASE_W]))));

            p_bad_code_disarms_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && (32'(wr_sel) == k) && (32'(wr_data[CODE_LSB +: CODE_W]) > MAX_CODE))
                |=> !cfg[k].en);
        end
    endgenerate

    p_stray_select_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (32'(wr_sel) >= NUM_WIN)) |=> $stable(cfg));

    p_idle_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg));

endmodule

// File: rtl/iwin_match.sv
module iwin_match
    import iwin_pkg::*;
#(
    parameter int MAX_CODE = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  win_cfg_t          cfg,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [ADDR_W-1:0] offset
);

    logic [SHAMT_W-1:0] shamt;
    logic [ADDR_W-1:0]  keep_mask;
    logic [ADDR_W-1:0]  base_full;
    logic               code_ok;

    always_comb begin
        shamt     = SHAMT_W'(GRAN_W) + SHAMT_W'(cfg.code);
        keep_mask = {ADDR_W{1'b1}} << shamt;
        base_full = {cfg.base, {GRAN_W{1'b0}}};
        code_ok   = (32'(cfg.code) <= MAX_CODE);
        hit       = cfg.en && code_ok && (((addr ^ base_full) & keep_mask) == '0);
        offset    = addr & ~keep_mask;
    end

    p_idle_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en |-> !hit);

    p_offset_in_granule_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && (cfg.code == '0)) |-> (offset[ADDR_W-1:GRAN_W] == '0));

endmodule

// File: rtl/iwin_prio.sv
module iwin_prio
    import iwin_pkg::*;
#(
    parameter int NUM_WIN = 3,
    localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_WIN-1:0] hit_vec,
    input  logic [ADDR_W-1:0] offsets [NUM_WIN],
    output logic              hit,
    output logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] host
);

    always_comb begin
        hit  = 1'b0;
        idx  = '0;
        host = '0;
        // Walk from the highest index down so the lowest one is kept.
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit  = 1'b1;
                idx  = IDX_W'(i);
                host = offsets[i];
            end
        end
    end

    generate
        for (genvar k = 1; k < NUM_WIN; k++) begin : g_prio_chk
            p_lowest_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (hit && (32'(idx) == k)) |-> ((hit_vec & NUM_WIN'((1 << k) - 1)) == '0));
        end
    endgenerate

endmodule

// File: rtl/iwin_decoder.sv
module iwin_decoder
    import iwin_pkg::*;
#(
    parameter int NUM_WIN  = 3,
    parameter int MAX_CODE = 11,
    localparam int IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [IDX_W-1:0]  cfg_wr_sel,
    input  logic [31:0]       cfg_wr_data,
    input  logic [31:0]       pci_addr,
    output logic              win_hit,
    output logic [IDX_W-1:0]  win_idx,
    output logic [31:0]       host_addr
);

    win_cfg_t [NUM_WIN-1:0] cfg;
    logic [NUM_WIN-1:0]     hit_vec;
    logic [ADDR_W-1:0]      offsets [NUM_WIN];

    iwin_regs #(
        .NUM_WIN  (NUM_WIN),
        .MAX_CODE (MAX_CODE)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_sel  (cfg_wr_sel),
        .wr_data (cfg_wr_data),
        .cfg     (cfg)
    );

    generate
        for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
            iwin_match #(
                .MAX_CODE (MAX_CODE)
            ) u_match (
                .clk    (clk),
                .rst_n  (rst_n),
                .cfg    (cfg[w]),
                .addr   (pci_addr),
                .hit    (hit_vec[w]),
                .offset (offsets[w])
            );
        end
    endgenerate

    iwin_prio #(
        .NUM_WIN (NUM_WIN)
    ) u_prio (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit_vec (hit_vec),
        .offsets (offsets),
        .hit     (win_hit),
        .idx     (win_idx),
        .host    (host_addr)
    );

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !win_hit);

    p_host_not_above_r6: assert property (@(posedge clk) disable iff (!rst_n)
        win_hit |-> (host_addr <= pci_addr));

    p_miss_zeroes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !win_hit |-> ((win_idx == '0) && (host_addr == '0)));

endmodule

// File: tb/iwin_decoder_bench.sv
module iwin_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [1:0]  cfg_wr_sel = '0;
    logic [31:0] cfg_wr_data = '0;
    logic [31:0] pci_addr = '0;
    logic        win_hit;
    logic [1:0]  win_idx;
    logic [31:0] host_addr;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    iwin_decoder u_iwin_decoder (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_sel  (cfg_wr_sel),
        .cfg_wr_data (cfg_wr_data),
        .pci_addr    (pci_addr),
        .win_hit     (win_hit),
        .win_idx     (win_idx),
        .host_addr   (host_addr)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic        hit;
        logic [1:0]  idx;
        logic [31:0] host;
    } probe_t;

    // Layout: w0 16 MB @0x1000_0000, w1 64 MB @0x1000_0000, w2 2 GB @0x8000_0000.
    localparam probe_t PROBES [8] = '{
        '{32'h10AB_CDEF, 1'b1, 2'd0, 32'h00AB_CDEF},  // R7 overlap -> w0
        '{32'h1000_0000, 1'b1, 2'd0, 32'h0000_0000},  // R3 lower edge
        '{32'h1234_5678, 1'b1, 2'd1, 32'h0234_5678},  // R6 w1 offset
        '{32'h13FF_FFFF, 1'b1, 2'd1, 32'h03FF_FFFF},  // R3 w1 top
        '{32'h1400_0000, 1'b0, 2'd0, 32'h0000_0000},  // R8 just above w1
        '{32'h0FFF_FFFF, 1'b0, 2'd0, 32'h0000_0000},  // R8 just below
        '{32'hDEAD_BEEF, 1'b1, 2'd2, 32'h5EAD_BEEF},  // R6 2 GB window
        '{32'h8000_0000, 1'b1, 2'd2, 32'h0000_0000}   // R3 2 GB edge
    };

    task automatic check(input string req, input logic e_hit,
                         input logic [1:0] e_idx, input logic [31:0] e_host);
        n_tests++;
        if (win_hit !== e_hit || win_idx !== e_idx || host_addr !== e_host) begin
            n_fail++;
            $display("FAIL %s addr=%08h: got hit=%0b idx=%0d host=%08h, expected hit=%0b idx=%0d host=%08h",
                     req, pci_addr, win_hit, win_idx, host_addr, e_hit, e_idx, e_host);
        end
    endtask

    task automatic probe(input logic [31:0] a);
        @(negedge clk);
        pci_addr = a;
        #1;
    endtask

    task automatic write_win(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_wr_en   = 1'b1;
        cfg_wr_sel  = sel;
        cfg_wr_data = data;
        @(posedge clk);
        #1;
        cfg_wr_en   = 1'b0;
    endtask

    task automatic report;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: nothing hits after reset
        probe(32'h1000_0000);
        check("R1", 1'b0, 2'd0, 32'h0);

        // R2: write visible only after the edge; R4 low junk ignored
        @(negedge clk);
        cfg_wr_en   = 1'b1;
        cfg_wr_sel  = 2'd0;
        cfg_wr_data = 32'h1004_ABCD;
        #1;
        check("R2", 1'b0, 2'd0, 32'h0);
        @(posedge clk);
        #1;
        cfg_wr_en = 1'b0;
        check("R2", 1'b1, 2'd0, 32'h0);
        probe(32'h10FF_FFFF);
        check("R4", 1'b1, 2'd0, 32'h00FF_FFFF);

        write_win(2'd1, 32'h1006_0000);
        write_win(2'd2, 32'h800B_0000);

        for (int i = 0; i < 8; i++) begin
            probe(PROBES[i].addr);
            check("R3/R6/R7/R8 table", PROBES[i].hit, PROBES[i].idx, PROBES[i].host);
        end

        // R9: select 3 names no window
        write_win(2'd3, 32'h0000_0000);
        probe(32'h0005_0000);
        check("R9", 1'b0, 2'd0, 32'h0);

        // R5: illegal code switches window 2 off
        write_win(2'd2, 32'h800C_0000);
        probe(32'hDEAD_BEEF);
        check("R5", 1'b0, 2'd0, 32'h0);

        // R10 + R3: unaligned base truncated to 2 GB -> covers 0..7FFF_FFFF
        write_win(2'd2, 32'h7FFB_0000);
        probe(32'h0500_0000);
        check("R10", 1'b1, 2'd2, 32'h0500_0000);

        // R3: code 0 gives a 1 MB window
        write_win(2'd0, 32'h2000_0000);
        probe(32'h200F_FFFF);
        check("R3", 1'b1, 2'd0, 32'h000F_FFFF);
        probe(32'h2010_0000);
        check("R3", 1'b1, 2'd2, 32'h2010_0000);
        probe(32'h10AB_CDEF);
        check("R10", 1'b1, 2'd1, 32'h00AB_CDEF);

        done = 1'b1;
        report();
    end

endmodule